// File: doc/BRIEF.md
# PWM Period Parameter Search Engine

This engine turns a requested PWM period and high time, both in microseconds, into the settings a PWM counter needs. The settings are a counter resolution (6 or 9 bits), a reference clock, a pre-divider, a power-of-two exponent and a duty count. The engine looks for the clock setup whose tick comes closest to the requested period divided by the counter length. It walks every combination of clock, pre-divider and exponent, one candidate per cycle, and stops the exponent walk early once the error grows. It then derives the duty count on a shared bit-serial divider.

A request starts with a one-cycle `startIn` pulse while the engine is idle. The period and duty inputs are captured on that edge. When the answer is ready, `donePulse` goes high for one cycle. The result ports then hold their values until the next `donePulse`. A request that cannot be met raises `errFlag` instead of producing settings.

Top module: `pwm_period_search`

## Requirements
- R1: A request is rejected when duty is greater than period, when period is below 7 us, or when period is above 384,000,000 us. On a rejected request, `errFlag` is 1 and `sizeNine`, `clkSel`, `divSel`, `expSel` and `dutyVal` are all 0. The next accepted request clears `errFlag`.
- R2: The target tick in ns is floor(period*1000/64), computed without overflow. If the target is at least 749,999,616, then `sizeNine`=1 (9-bit counter, N=9) and the target is divided by 8. Otherwise `sizeNine`=0 (6-bit counter, N=6).
- R3: Each candidate tick is base*2^m. The base is the pre-divide ratio times the reference period. `clkSel` codes are 0 for 976,562 ns, 1 for 30,517 ns and 2 for 52 ns. `divSel` codes 0..3 select the ratios 1, 3, 5 and 6. `expSel` is m, from 0 to 7. The reported setting is the one with the smallest absolute error to the target.
- R4: The walk order is clock (outer loop), then pre-divider, then exponent (inner loop). A setting replaces the best only when its error is strictly smaller, so the first minimum in walk order wins.
- R5: For m>0, the exponent walk of a clock/pre-divider pair stops after evaluating a candidate whose error exceeds the remembered previous error. That stopping candidate does not update the remembered error. The remembered error carries over into the next pair.
- R6: The duty count is (duty<<N)/period when duty < 2^(32-N). Otherwise it is duty/(period>>N). Both divisions truncate.
- R7: `dutyVal` is clamped to 2^N-1.
- R8: Call the edge that accepts `startIn` edge 0. `donePulse` is high for exactly one cycle: after edge 1 for a rejected request, and after edge 33+S for an accepted one, where S is the number of candidates evaluated. The result ports and `errFlag` change only together with `donePulse`.
- R9: `startIn` is ignored while a request is in progress. The period and duty inputs are read only at edge 0.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startIn | input | 1 | Request strobe, honoured only while idle |
| periodUs | input | 32 | Requested period in microseconds |
| dutyUs | input | 32 | Requested high time in microseconds |
| sizeNine | output | 1 | 1 = 9-bit counter, 0 = 6-bit counter |
| clkSel | output | 2 | Reference clock code |
| divSel | output | 2 | Pre-divider code |
| expSel | output | 3 | Exponent m |
| dutyVal | output | 9 | Duty count, clamped |
| donePulse | output | 1 | One-cycle result strobe |
| errFlag | output | 1 | Last request was rejected |

## Verification
The result latency depends on the data. A rejected request answers after two edges. An accepted one answers after 34+S edges, and S varies from 24 to 96 with the early exits. The bench model therefore counts S for every request while it computes the expected settings, and it checks `donePulse` on every cycle against that schedule. The result fields are compared in the single cycle where the strobe is due, and again a few cycles later to confirm they are held. A start pulse injected mid-search, together with inputs scrambled after acceptance, shows that the schedule and the values of the request already in progress do not move.

// File: rtl/pwm_search_pkg.sv
package pwm_search_pkg;

  localparam int DW        = 32;
  localparam int NCLK      = 3;
  localparam int NDIV      = 4;
  localparam int EXP_BITS  = 3;
  localparam int EXP_LAST  = (1 << EXP_BITS) - 1;
  localparam int SMALL_N   = 6;
  localparam int LARGE_N   = 9;
  localparam int NS_PER_US = 1000;
  localparam int NS_PER_S  = 1000000000;

  // reference tick periods in integer nanoseconds
  function automatic logic [DW-1:0] refNs(input logic [1:0] idx);
    case (idx)
      2'd0:    refNs = DW'(NS_PER_S / 1024);
      2'd1:    refNs = DW'(NS_PER_S / 32768);
      2'd2:    refNs = DW'(NS_PER_S / 19200000);
      default: refNs = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] preRatio(input logic [1:0] idx);
    case (idx)
      2'd0:    preRatio = DW'(1);
      2'd1:    preRatio = DW'(3);
      2'd2:    preRatio = DW'(5);
      default: preRatio = DW'(6);
    endcase
  endfunction

  function automatic logic [DW-1:0] baseTick(input logic [1:0] c, input logic [1:0] d);
    baseTick = refNs(c) * preRatio(d);
  endfunction

  // largest candidate reachable: slowest clock, biggest ratio, top exponent
  localparam logic [DW-1:0] MAX_TICK = DW'((NS_PER_S / 1024) * 6) << EXP_LAST;

  typedef struct packed {
    logic capture;
    logic reject;
    logic loadSearch;
    logic step;
    logic loadDiv;
    logic divStep;
    logic finish;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PREP   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_DIV    = 2'd3
  } searchState_t;

endpackage

// File: rtl/pwm_search_div.sv
module pwm_search_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] numIn,
  input  logic [W-1:0] denIn,
  output logic [W-1:0] quoNext,
  output logic         lastStep
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  remR, quoR, denR;
  logic [CW-1:0] cntR;
  logic [W:0]    remSh, diff;

  assign remSh    = {remR, quoR[W-1]};
  assign diff     = remSh - {1'b0, denR};
  assign quoNext  = {quoR[W-2:0], ~diff[W]};
  assign lastStep = (cntR == CW'(W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      denR <= '0;
      cntR <= '0;
    end else if (load) begin
      remR <= '0;
      quoR <= numIn;
      denR <= denIn;
      cntR <= '0;
    end else if (step) begin
      remR <= diff[W] ? remSh[W-1:0] : diff[W-1:0];
      quoR <= quoNext;
      cntR <= cntR + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_search_ctrl.sv
module pwm_search_ctrl
  import pwm_search_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  input  logic         badReq,
  input  logic         searchLast,
  input  logic         divLast,
  output ctrlStrobes_t strobes
);
  searchState_t stateR, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = stateR;
    case (stateR)
      ST_IDLE: if (startIn) begin
        strobes.capture = 1'b1;
        stateNext       = ST_PREP;
      end
      ST_PREP: if (badReq) begin
        strobes.reject = 1'b1;
        stateNext      = ST_IDLE;
      end else begin
        strobes.loadSearch = 1'b1;
        stateNext          = ST_SEARCH;
      end
      ST_SEARCH: begin
        strobes.step = 1'b1;
        if (searchLast) begin
          strobes.loadDiv = 1'b1;
          stateNext       = ST_DIV;
        end
      end
      ST_DIV: begin
        strobes.divStep = 1'b1;
        if (divLast) begin
          strobes.finish = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateR <= ST_IDLE;
    else       stateR <= stateNext;
  end
endmodule

// File: rtl/pwm_search_dpath.sv
module pwm_search_dpath
  import pwm_search_pkg::*;
#(
  parameter int          MIN_US = 7,
  parameter int unsigned MAX_US = 384000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [DW-1:0] periodUs,
  input  logic [DW-1:0] dutyUs,
  output logic          badReq,
  output logic          searchLast,
  output logic          divLast,
  output logic          sizeNine,
  output logic [1:0]    clkSel,
  output logic [1:0]    divSel,
  output logic [EXP_BITS-1:0] expSel,
  output logic [LARGE_N-1:0]  dutyVal,
  output logic          donePulse,
  output logic          errFlag
);
  localparam int PW = DW + 10;             // room for period * 1000
  localparam int TW = PW - SMALL_N;        // unscaled target width
  localparam logic [LARGE_N-1:0] MAX_SMALL = LARGE_N'((1 << SMALL_N) - 1);
  localparam logic [LARGE_N-1:0] MAX_LARGE = LARGE_N'((1 << LARGE_N) - 1);

  // captured request
  logic [DW-1:0] perR, dutyR;

  // search state
  logic [DW-1:0] targetR, candR, lastErrR, minErrR;
  logic          wideR;
  logic [1:0]    clkIdx, divIdx, bestClk, bestDiv;
  logic [EXP_BITS-1:0] expIdx, bestExp;

  // ---------------- request screening and target ----------------
  logic [PW-1:0] scaled;
  logic [TW-1:0] tgtFull;
  logic          tgtWide;

  assign badReq  = (dutyR > perR) || (perR < DW'(MIN_US)) || (perR > DW'(MAX_US));
  assign scaled  = {10'b0, perR} * PW'(NS_PER_US);
  assign tgtFull = TW'(scaled >> SMALL_N);
  assign tgtWide = (tgtFull >= TW'(MAX_TICK));

  // ---------------- candidate evaluation ----------------
  logic [DW-1:0] errNow;
  logic          better, rising, groupEnd;
  logic [1:0]    clkNext, divNext;

  assign errNow     = (targetR > candR) ? (targetR - candR) : (candR - targetR);
  assign better     = errNow < minErrR;
  assign rising     = (expIdx != '0) && (errNow > lastErrR);
  assign groupEnd   = rising || (expIdx == EXP_BITS'(EXP_LAST));
  assign searchLast = groupEnd && (clkIdx == 2'(NCLK - 1)) && (divIdx == 2'(NDIV - 1));

  always_comb begin
    if (divIdx == 2'(NDIV - 1)) begin
      divNext = '0;
      clkNext = clkIdx + 1'b1;
    end else begin
      divNext = divIdx + 1'b1;
      clkNext = clkIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perR     <= '0;
      dutyR    <= '0;
      targetR  <= '0;
      candR    <= '0;
      lastErrR <= '0;
      minErrR  <= '0;
      wideR    <= 1'b0;
      clkIdx   <= '0;
      divIdx   <= '0;
      expIdx   <= '0;
      bestClk  <= '0;
      bestDiv  <= '0;
      bestExp  <= '0;
    end else begin
      if (strobes.capture) begin
        perR  <= periodUs;
        dutyR <= dutyUs;
      end
      if (strobes.loadSearch) begin
        wideR    <= tgtWide;
        targetR  <= tgtWide ? DW'(tgtFull >> (LARGE_N - SMALL_N)) : DW'(tgtFull);
        candR    <= baseTick(2'd0, 2'd0);
        lastErrR <= '1;
        minErrR  <= '1;
        clkIdx   <= '0;
        divIdx   <= '0;
        expIdx   <= '0;
        bestClk  <= '0;
        bestDiv  <= '0;
        bestExp  <= '0;
      end else if (strobes.step) begin
        if (better) begin
          minErrR <= errNow;
          bestClk <= clkIdx;
          bestDiv <= divIdx;
          bestExp <= expIdx;
        end
        if (!rising) lastErrR <= errNow;
        if (groupEnd) begin
          expIdx <= '0;
          divIdx <= divNext;
          clkIdx <= clkNext;
          candR  <= baseTick(clkNext, divNext);
        end else begin
          expIdx <= expIdx + 1'b1;
          candR  <= candR << 1;
        end
      end
    end
  end

  // ---------------- duty count ----------------
  logic [DW-1:0] numSel, denSel, quoNext;
  logic          smallDuty;
  logic [LARGE_N-1:0] dutyClamp, maxVal;

  always_comb begin
    if (wideR) begin
      smallDuty = (dutyR >> (DW - LARGE_N)) == '0;
      numSel    = smallDuty ? (dutyR << LARGE_N) : dutyR;
      denSel    = smallDuty ? perR : (perR >> LARGE_N);
      maxVal    = MAX_LARGE;
    end else begin
      smallDuty = (dutyR >> (DW - SMALL_N)) == '0;
      numSel    = smallDuty ? (dutyR << SMALL_N) : dutyR;
      denSel    = smallDuty ? perR : (perR >> SMALL_N);
      maxVal    = MAX_SMALL;
    end
    dutyClamp = (quoNext > DW'(maxVal)) ? maxVal : quoNext[LARGE_N-1:0];
  end

  pwm_search_div #(.W(DW)) uDiv (
    .clk      (clk),
    .rstN     (rstN),
    .load     (strobes.loadDiv),
    .step     (strobes.divStep),
    .numIn    (numSel),
    .denIn    (denSel),
    .quoNext  (quoNext),
    .lastStep (divLast)
  );

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeNine  <= 1'b0;
      clkSel    <= '0;
      divSel    <= '0;
      expSel    <= '0;
      dutyVal   <= '0;
      donePulse <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      donePulse <= strobes.reject | strobes.finish;
      if (strobes.reject) begin
        sizeNine <= 1'b0;
        clkSel   <= '0;
        divSel   <= '0;
        expSel   <= '0;
        dutyVal  <= '0;
        errFlag  <= 1'b1;
      end else if (strobes.finish) begin
        sizeNine <= wideR;
        clkSel   <= bestClk;
        divSel   <= bestDiv;
        expSel   <= bestExp;
        dutyVal  <= dutyClamp;
        errFlag  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_period_search.sv
module pwm_period_search
  import pwm_search_pkg::*;
#(
  parameter int          MIN_US = 7,
  parameter int unsigned MAX_US = 384000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic [31:0] periodUs,
  input  logic [31:0] dutyUs,
  output logic        sizeNine,
  output logic [1:0]  clkSel,
  output logic [1:0]  divSel,
  output logic [2:0]  expSel,
  output logic [8:0]  dutyVal,
  output logic        donePulse,
  output logic        errFlag
);
  ctrlStrobes_t strobes;
  logic badReq, searchLast, divLast;

  pwm_search_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startIn    (startIn),
    .badReq     (badReq),
    .searchLast (searchLast),
    .divLast    (divLast),
    .strobes    (strobes)
  );

  pwm_search_dpath #(.MIN_US(MIN_US), .MAX_US(MAX_US)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .periodUs   (periodUs),
    .dutyUs     (dutyUs),
    .badReq     (badReq),
    .searchLast (searchLast),
    .divLast    (divLast),
    .sizeNine   (sizeNine),
    .clkSel     (clkSel),
    .divSel     (divSel),
    .expSel     (expSel),
    .dutyVal    (dutyVal),
    .donePulse  (donePulse),
    .errFlag    (errFlag)
  );
endmodule

// File: rtl/pwm_search_chk.sv
module pwm_search_chk (
  input logic        clk,
  input logic        rstN,
  input logic        startIn,
  input logic [31:0] periodUs,
  input logic [31:0] dutyUs,
  input logic        sizeNine,
  input logic [1:0]  clkSel,
  input logic [1:0]  divSel,
  input logic [2:0]  expSel,
  input logic [8:0]  dutyVal,
  input logic        donePulse,
  input logic        errFlag
);
  // R8: the strobe never lasts two cycles
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8: results move only with the strobe
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !donePulse |-> $stable({sizeNine, clkSel, divSel, expSel, dutyVal, errFlag}));

  // R1: a rejected request reports cleared settings
  p_err_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!sizeNine && clkSel == 2'd0 && divSel == 2'd0 && expSel == 3'd0 && dutyVal == 9'd0));

  // R7: six-bit results never exceed their range
  p_clamp_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sizeNine |-> (dutyVal < 9'd64));

  // R3: only three clock codes exist
  p_clk_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    clkSel != 2'd3);
endmodule

bind pwm_period_search pwm_search_chk uChk (.*);

// File: tb/sim_pwm_period_search.sv
`timescale 1ns/1ps
module sim_pwm_period_search;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] periodUs = '0;
  logic [31:0] dutyUs = '0;
  logic        sizeNine, donePulse, errFlag;
  logic [1:0]  clkSel, divSel;
  logic [2:0]  expSel;
  logic [8:0]  dutyVal;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  pwm_period_search u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finishRun();
    end
  end

  // behavioural model of the requirements
  typedef struct {
    bit err; bit wide; int c; int v; int m; longint duty; int steps;
  } expect_t;

  function automatic expect_t model(input longint p, input longint d);
    expect_t r;
    longint refs[3] = '{976562, 30517, 52};
    longint pre[4]  = '{1, 3, 5, 6};
    longint tgt, t, e, minE, lastE, q, nb;
    r = '{0, 0, 0, 0, 0, 0, 0};
    if (d > p || p < 7 || p > 384000000) begin
      r.err = 1;
      return r;
    end
    tgt = (p * 1000) >> 6;                      // R2
    nb = 6;
    if (tgt >= 749999616) begin nb = 9; tgt = tgt >> 3; r.wide = 1; end
    minE = 64'hFFFFFFFF; lastE = 64'hFFFFFFFF;
    for (int c = 0; c < 3; c++)                 // R4 order
      for (int v = 0; v < 4; v++) begin
        t = pre[v] * refs[c];
        for (int m = 0; m < 8; m++) begin
          r.steps++;
          e = (tgt > t) ? tgt - t : t - tgt;
          if (e < minE) begin minE = e; r.c = c; r.v = v; r.m = m; end
          if (m > 0 && e > lastE) break;        // R5
          lastE = e;
          t = t << 1;
        end
      end
    if (d < (longint'(1) << (32 - nb))) q = (d << nb) / p;   // R6
    else q = d / (p >> nb);
    if (q > (longint'(1) << nb) - 1) q = (longint'(1) << nb) - 1;  // R7
    r.duty = q;
    return r;
  endfunction

  task automatic checkFields(input expect_t x, input string when);
    chk(errFlag == x.err, {"R1 errFlag ", when}, errFlag, x.err);
    chk(sizeNine == x.wide, {"R2 sizeNine ", when}, sizeNine, x.wide);
    chk(clkSel == x.c && divSel == x.v, {"R3 R4 clock/divider ", when},
        clkSel * 4 + divSel, x.c * 4 + x.v);
    chk(expSel == x.m, {"R5 exponent ", when}, expSel, x.m);
    chk(dutyVal == x.duty, {"R6 R7 duty ", when}, dutyVal, x.duty);
  endtask

  task automatic runReq(input longint p, input longint d, input bit inject);
    expect_t x;
    int lat;
    x = model(p, d);
    lat = x.err ? 1 : 33 + x.steps;
    @(negedge clk);
    startIn = 1'b1; periodUs = 32'(p); dutyUs = 32'(d);
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0; periodUs = 32'hDEAD_BEEF; dutyUs = 32'h1234_5678;   // R9
    for (int i = 1; i <= lat + 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      startIn = (inject && i == 5);                                    // R9
      if (inject && i == 5) begin periodUs = 32'd9; dutyUs = 32'd9; end
      chk(donePulse == (i == lat), "R8 done timing", donePulse, (i == lat));
      if (i == lat) checkFields(x, "at done");
    end
    startIn = 1'b0;
    checkFields(x, "held");                                            // R8
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk(donePulse == 0 && errFlag == 0, "R10 reset flags", {donePulse, errFlag}, 0);
    chk({sizeNine, clkSel, divSel, expSel, dutyVal} == '0, "R10 reset fields",
        {sizeNine, clkSel, divSel, expSel, dutyVal}, 0);
    rstN = 1'b1;
    @(negedge clk);
    runReq(27, 13, 0);
    runReq(7, 3, 0);                 // smallest legal period
    runReq(6, 3, 0);                 // R1 period too small
    runReq(50000, 12345, 0);         // clears errFlag after reject
    runReq(27, 28, 0);               // R1 duty above period
    runReq(384000001, 1, 0);         // R1 period too large
    runReq(384000000, 192000000, 0); // largest period, wide duty branch
    runReq(47999975, 1000, 0);       // R2 just below widening
    runReq(47999976, 1000, 0);       // R2 just above widening
    runReq(100000000, 50000000, 0);
    runReq(1000, 1000, 0);           // R7 clamp
    runReq(1000000, 1, 0);
    runReq(5000000, 2500000, 0);
    runReq(2000, 500, 1);            // R9 start during search ignored
    runReq(20, 7, 0);
    finishRun();
  end
endmodule